// File: doc/BRIEF.md
# Quad-SPI PSRAM Word Bridge

This block lets a simple 32-bit word requester use a serial PSRAM as if it were flat RAM. After reset it drives the device in single-line SPI at a slow serial clock. It sends the one command that moves the device into four-lane mode, and then raises the serial clock rate. From then on, every bus word becomes a four-lane SDR transaction: an instruction, a 24-bit byte address and eight data nibbles. A read also has six turnaround clocks before its data.

Chip select stays low after a word completes, so the next word of an ascending run in the same direction costs only its eight data clocks. The transaction is closed, and a new instruction and address are sent, in four cases: the programmed word limit is reached, the next word would start a new 1024-byte device page, the request breaks the run, or the requester stays silent for longer than the programmed idle time. Because of this rule the device never wraps inside a page. Byte selection from a returned word is left to the requester.

Top module: `qpsram_bridge`

## Requirements
- R1: After reset the first transaction is the byte 0x35, sent most significant bit first on IO0 alone (io_oe = 4'b0001) over 8 serial clocks, with a serial clock period of SLOW_DIV (5) system cycles.
- R2: Once that command ends, every later serial clock period is FAST_DIV (2) system cycles. Bus requests made during start-up wait until the command has finished.
- R3: A new four-lane transaction sends the instruction (0xEB for read, 0x38 for write) in 2 clocks, then the byte address of the word (word address times 4) in 6 clocks. Both go most significant nibble first on IO[3:0] with io_oe = 4'hF.
- R4: A read leaves io_oe = 0 for 6 turnaround clocks and then for 8 data clocks. It assembles the nibbles most significant first, so the byte at the lowest address lands in bits 31:24.
- R5: A write puts its 8 data nibbles directly after the address, most significant first, with io_oe = 4'hF. Bits 31:24 go to the lowest byte address.
- R6: bus_ready is high for exactly one cycle when the serial transfer of the requested word completes. bus_rdata holds the read word in that cycle.
- R7: A request for the next word address, in the same direction, made while chip select is still low, continues the open transaction with 8 data clocks only.
- R8: With cfg_boundary = B (nonzero), no transaction carries more than B words. B = 0 means only the page rule applies.
- R9: A transaction never continues into a word whose address is a multiple of 256 (a 1024-byte page start), whatever cfg_boundary is set to.
- R10: With no request pending, cs_n rises exactly cfg_timeout+1 cycles after the bus_ready pulse.
- R11: sclk is low whenever cs_n is high (mode 0), and cs_n stays high for at least FAST_DIV cycles between transactions.
- R12: A request that breaks the run (a different address or direction) closes the open transaction and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request valid. Held with stable fields until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Word address |
| bus_wdata | input | 32 | Write word |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read word, valid with bus_ready |
| cfg_boundary | input | 8 | Maximum words per transaction, 0 = page limit only |
| cfg_timeout | input | 8 | Idle cycles before chip select is released |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Device select, active low |
| io_out | output | 4 | Serial data out |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Serial data in |

## Verification
The bench builds the block with its default values: dividers of 5 and 2, a 256-word page and 24-bit addresses. A behavioural device model wraps inside its 1024-byte page, as real parts do. Eight-word bursts start at every word offset from 249 to 255 and are swept against word limits of 0, 1, 3 and 8. For each case the bench computes the expected transaction count and data arithmetically. A guard word at the start of the page would expose any wrap that the splitting failed to prevent.

// File: rtl/qpsram_pkg.sv
package qpsram_pkg;
  typedef enum logic [2:0] {ST_BOOT, ST_XFER, ST_HOLD, ST_GAP, ST_IDLE} qst_e;
  localparam logic [7:0] OP_QUAD_ON = 8'h35;
  localparam logic [7:0] OP_QREAD   = 8'hEB;
  localparam logic [7:0] OP_QWRITE  = 8'h38;
endpackage

// File: rtl/qpsram_clkdiv.sv
module qpsram_clkdiv #(
  parameter int SLOW_DIV = 5,
  parameter int FAST_DIV = 2,
  localparam int DIV_W = $clog2(SLOW_DIV + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic sclk,
  output logic sck_end
);
  logic [DIV_W-1:0] cnt, cnt_nx, last_v, low_v;

  always_comb begin
    last_v = fast ? DIV_W'(FAST_DIV - 1) : DIV_W'(SLOW_DIV - 1);
    low_v  = fast ? DIV_W'(FAST_DIV - FAST_DIV / 2) : DIV_W'(SLOW_DIV - SLOW_DIV / 2);
    cnt_nx = (cnt == last_v) ? '0 : cnt + 1'b1;
  end

  assign sck_end = run && (cnt == last_v);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      sclk <= (cnt_nx >= low_v);
    end
  end

  // R11: clock parks low as soon as the sequencer stops it
  p_park_low_r11: assert property (@(posedge clk) disable iff (rst) !run |=> !sclk);
endmodule

// File: rtl/qpsram_shifter.sv
module qpsram_shifter (
  input  logic        clk,
  input  logic        rst,
  input  logic        quad,
  input  logic        load,
  input  logic [63:0] load_word,
  input  logic [4:0]  load_oe,
  input  logic        shift,
  input  logic        capture,
  input  logic [3:0]  io_in,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  output logic [31:0] cap_next
);
  logic [63:0] sh;
  logic [4:0]  oe_left;
  logic [31:0] cap;

  assign cap_next = {cap[27:0], io_in};
  assign io_out   = quad ? sh[63:60] : {3'b000, sh[63]};
  assign io_oe    = (oe_left == '0) ? 4'h0 : (quad ? 4'hF : 4'h1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      oe_left <= '0;
      cap     <= '0;
    end else if (load) begin
      sh      <= load_word;
      oe_left <= load_oe;
    end else if (shift) begin
      sh <= quad ? {sh[59:0], 4'h0} : {sh[62:0], 1'b0};
      if (oe_left != '0) oe_left <= oe_left - 1'b1;
      if (capture) cap <= cap_next;
    end
  end

  // R4: lines are released whenever read data is being captured
  p_rd_released_r4: assert property (@(posedge clk) disable iff (rst)
    (shift && capture) |-> (io_oe == 4'h0));
endmodule

// File: rtl/qpsram_bridge.sv
module qpsram_bridge #(
  parameter int SLOW_DIV   = 5,
  parameter int FAST_DIV   = 2,
  parameter int AW         = 24,
  parameter int PAGE_WORDS = 256,
  parameter int BND_W      = 8,
  parameter int TMO_W      = 8,
  localparam int WA    = AW - 2,
  localparam int PG_W  = $clog2(PAGE_WORDS),
  localparam int DIV_W = $clog2(SLOW_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [WA-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic             bus_ready,
  output logic [31:0]      bus_rdata,
  input  logic [BND_W-1:0] cfg_boundary,
  input  logic [TMO_W-1:0] cfg_timeout,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  import qpsram_pkg::*;

  qst_e             st;
  logic             quad, fast, rd;
  logic [4:0]       clk_left;
  logic [WA-1:0]    nxt_w;
  logic [BND_W-1:0] words;
  logic [TMO_W-1:0] tmo;
  logic [DIV_W-1:0] gap;
  logic             sck_end, load, capture, seq_ok;
  logic [63:0]      load_word;
  logic [4:0]       load_oe;
  logic [31:0]      cap_next;

  qpsram_clkdiv #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_div (
    .clk(clk), .rst(rst), .run(st == ST_XFER), .fast(fast),
    .sclk(sclk), .sck_end(sck_end));

  qpsram_shifter u_shf (
    .clk(clk), .rst(rst), .quad(quad), .load(load), .load_word(load_word),
    .load_oe(load_oe), .shift(sck_end), .capture(capture), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .cap_next(cap_next));

  assign capture = rd && quad && (st == ST_XFER) && (clk_left <= 5'd8);
  assign seq_ok  = bus_req && (bus_we == !rd) && (bus_addr == nxt_w)
                && ((cfg_boundary == '0) || (words < cfg_boundary))
                && (nxt_w[PG_W-1:0] != '0);

  always_comb begin
    load      = 1'b0;
    load_word = '0;
    load_oe   = '0;
    case (st)
      ST_BOOT: begin
        load = 1'b1; load_word = {OP_QUAD_ON, 56'h0}; load_oe = 5'd8;
      end
      ST_IDLE: if (bus_req) begin
        load      = 1'b1;
        load_word = bus_we ? {OP_QWRITE, bus_addr, 2'b00, bus_wdata}
                           : {OP_QREAD, bus_addr, 2'b00, 32'h0};
        load_oe   = bus_we ? 5'd16 : 5'd8;
      end
      ST_HOLD: if (seq_ok) begin
        load = 1'b1; load_word = {bus_wdata, 32'h0}; load_oe = bus_we ? 5'd8 : 5'd0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_BOOT; quad <= 1'b0; fast <= 1'b0; rd <= 1'b0; cs_n <= 1'b1;
      clk_left <= '0; nxt_w <= '0; words <= '0; tmo <= '0; gap <= '0;
      bus_ready <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_ready <= 1'b0;
      case (st)
        ST_BOOT: begin
          cs_n <= 1'b0; clk_left <= 5'd8; st <= ST_XFER;
        end
        ST_IDLE: if (bus_req) begin
          cs_n     <= 1'b0;
          clk_left <= bus_we ? 5'd16 : 5'd22;
          rd       <= !bus_we;
          nxt_w    <= bus_addr + 1'b1;
          words    <= BND_W'(1);
          st       <= ST_XFER;
        end
        ST_XFER: if (sck_end) begin
          clk_left <= clk_left - 1'b1;
          if (clk_left == 5'd1) begin
            if (!quad) begin
              quad <= 1'b1; fast <= 1'b1; cs_n <= 1'b1;
              gap  <= DIV_W'(SLOW_DIV - 1); st <= ST_GAP;
            end else begin
              bus_ready <= 1'b1;
              if (rd) bus_rdata <= cap_next;
              tmo <= '0; st <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (seq_ok) begin
            clk_left <= 5'd8;
            nxt_w    <= nxt_w + 1'b1;
            if (words != '1) words <= words + 1'b1;
            st <= ST_XFER;
          end else if (bus_req || (tmo == cfg_timeout)) begin
            cs_n <= 1'b1; gap <= DIV_W'(FAST_DIV - 1); st <= ST_GAP;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap == '0) st <= ST_IDLE;
          else gap <= gap - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: completion is a single-cycle pulse
  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (rst) bus_ready |=> !bus_ready);
  // R11: mode 0 idle level and a chip-select gap of more than one cycle
  p_idle_low_r11: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);
  p_cs_gap_r11: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |=> cs_n);
  // R8: word count within the programmed limit
  p_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && quad && cfg_boundary != '0) |-> (words <= cfg_boundary));
  // R9: a continued word never starts a page
  p_no_page_cross_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && $past(st) == ST_HOLD) |-> (nxt_w[PG_W-1:0] != PG_W'(1)));
  // R10: idle expiry releases chip select
  p_timeout_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD && !bus_req && tmo == cfg_timeout) |=> cs_n);
  // R1: single-lane drive before quad mode
  p_spi_lane_r1: assert property (@(posedge clk) disable iff (rst)
    (!quad && io_oe != 4'h0) |-> (io_oe == 4'h1 && !fast));
endmodule

// File: tb/qpsram_bridge_bench.sv
`timescale 1ns/1ps
module qpsram_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [21:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [7:0]  cfg_boundary = 8'd8, cfg_timeout = 8'd40;
  logic        sclk, cs_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = 4'h0;

  always #2 clk = ~clk;

  qpsram_bridge u_qpsram_bridge (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .cfg_boundary(cfg_boundary), .cfg_timeout(cfg_timeout), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- device model (wraps within its 1024-byte page) ----------------
  logic [7:0]  mem [0:4095];
  logic [7:0]  spi_cmd = 8'h0, first_cmd = 8'h0, cmd = 8'h0, wbyte = 8'h0, rb;
  logic [23:0] adr = '0;
  bit qmode = 0;
  int n = 0, k = 0, txns = 0, proto_err = 0;
  int cyc = 0, last_rise = 0, init_bad = 0, init_seen = 0, min_fast = 1000;
  int gap_run = 0, min_gap = 1000;

  function automatic int idx(input logic [23:0] a, input int j);
    logic [9:0] off;
    off = a[9:0] + 10'(j);
    return int'({a[11:10], off});
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cs_n) gap_run++;
    else if (gap_run > 0) begin
      if (txns > 1 && gap_run < min_gap) min_gap = gap_run;
      gap_run = 0;
    end
  end

  always @(negedge cs_n) begin n = 0; txns++; end

  always @(posedge sclk) if (!cs_n) begin
    n++;
    if (n >= 2) begin
      if (!qmode) begin init_seen++; if (cyc - last_rise != 5) init_bad++; end
      else if (cyc - last_rise < min_fast) min_fast = cyc - last_rise;
    end
    last_rise = cyc;
    if (!qmode) begin
      spi_cmd = {spi_cmd[6:0], io_out[0]};
      if (io_oe != 4'h1) proto_err++;
      if (n == 8) begin first_cmd = spi_cmd; if (spi_cmd == 8'h35) qmode = 1; end
    end else if (n <= 2) begin
      cmd = {cmd[3:0], io_out}; if (io_oe != 4'hF) proto_err++;
    end else if (n <= 8) begin
      adr = {adr[19:0], io_out}; if (io_oe != 4'hF) proto_err++;
    end else if (cmd == 8'h38) begin
      if (io_oe != 4'hF) proto_err++;
      k = n - 9;
      wbyte = {wbyte[3:0], io_out};
      if (k % 2 == 1) mem[idx(adr, k / 2)] = wbyte;
    end else if (io_oe != 4'h0) proto_err++;
  end

  always @(negedge sclk) if (!cs_n && qmode && cmd == 8'hEB && n >= 14) begin
    k = n - 14;
    rb = mem[idx(adr, k / 2)];
    #1 io_in = (k % 2 == 0) ? rb[7:4] : rb[3:0];
  end

  always @(negedge clk) if (!rst && cs_n && sclk) proto_err++;

  // ---------------- bus access ----------------
  task automatic access(input bit we, input int waddr, input logic [31:0] wd, output logic [31:0] rdv);
    bus_req = 1'b1; bus_we = we; bus_addr = 22'(waddr); bus_wdata = wd;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (bus_ready) break;
    end
    rdv = bus_rdata;
    bus_req = 1'b0;
  endtask

  function automatic int exp_txns(input int start, input int len, input int bnd);
    int t = 0, w = 0;
    for (int i = 0; i < len; i++) begin
      if (i == 0 || (bnd != 0 && w == bnd) || ((start + i) % 256 == 0)) begin t++; w = 1; end
      else w++;
    end
    return t;
  endfunction

  function automatic logic [31:0] pat(input int b, input int s, input int i);
    return 32'hC3000000 ^ (32'(b) << 16) ^ (32'(s) << 8) ^ 32'(i * 37 + 1);
  endfunction

  logic [31:0] rv;
  int t0;

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    // reset state
    chk(cs_n == 1'b1, "reset cs_n", 32'(cs_n), 1);
    chk(sclk == 1'b0, "reset sclk", 32'(sclk), 0);
    chk(bus_ready == 1'b0, "reset bus_ready", 32'(bus_ready), 0);
    rst = 1'b0;
    // R1/R2: first request waits for start-up
    access(1'b1, 64, 32'h11223344, rv);
    chk(first_cmd == 8'h35, "R1 start-up byte", 32'(first_cmd), 32'h35);
    chk(init_seen == 7 && init_bad == 0, "R1 slow period", 32'(init_bad), 0);
    chk(min_fast == 2, "R2 fast period", 32'(min_fast), 2);
    // R3/R5: write framing and byte order
    chk(cmd == 8'h38 && adr == 24'h000100, "R3 write instr/addr", {cmd, adr}, 32'h38000100);
    chk({mem[256], mem[257], mem[258], mem[259]} == 32'h11223344, "R5 write bytes",
        {mem[256], mem[257], mem[258], mem[259]}, 32'h11223344);
    // R10: idle release timing
    cfg_timeout = 8'd5;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b0, "R10 still selected", 32'(cs_n), 0);
    @(negedge clk);
    chk(cs_n == 1'b1, "R10 released", 32'(cs_n), 1);
    cfg_timeout = 8'd40;
    repeat (10) @(negedge clk);
    // R4/R6: read back
    access(1'b0, 64, 32'h0, rv);
    chk(rv == 32'h11223344, "R4 R6 read word", rv, 32'h11223344);
    chk(cmd == 8'hEB && adr == 24'h000100, "R3 read instr/addr", {cmd, adr}, 32'hEB000100);
    repeat (60) @(negedge clk);
    // R7: sequential continuation, R12: breaks
    t0 = txns;
    access(1'b1, 400, 32'hA0A0A0A0, rv);
    access(1'b1, 401, 32'hB1B1B1B1, rv);
    chk(txns - t0 == 1, "R7 continue", 32'(txns - t0), 1);
    access(1'b0, 402, 32'h0, rv);
    chk(txns - t0 == 2, "R12 direction change", 32'(txns - t0), 2);
    access(1'b0, 500, 32'h0, rv);
    chk(txns - t0 == 3, "R12 address jump", 32'(txns - t0), 3);
    access(1'b0, 401, 32'h0, rv);
    chk(rv == 32'hB1B1B1B1, "R7 continued data", rv, 32'hB1B1B1B1);
    repeat (60) @(negedge clk);
    // page-start guard word
    access(1'b1, 0, 32'h5EED5EED, rv);
    repeat (60) @(negedge clk);
    // R8/R9 sweep
    for (int bi = 0; bi < 4; bi++) begin
      for (int s = 249; s <= 255; s++) begin
        int b;
        b = (bi == 0) ? 0 : (bi == 1) ? 1 : (bi == 2) ? 3 : 8;
        cfg_boundary = 8'(b);
        t0 = txns;
        for (int i = 0; i < 8; i++) access(1'b1, s + i, pat(b, s, i), rv);
        chk(txns - t0 == exp_txns(s, 8, b), (b == 0) ? "R9 write split" : "R8 write split",
            32'(txns - t0), 32'(exp_txns(s, 8, b)));
        t0 = txns;
        for (int i = 0; i < 8; i++) begin
          access(1'b0, s + i, 32'h0, rv);
          chk(rv == pat(b, s, i), "R4 burst read", rv, pat(b, s, i));
        end
        chk(txns - t0 == exp_txns(s, 8, b) + 0, (b == 0) ? "R9 read split" : "R8 read split",
            32'(txns - t0), 32'(exp_txns(s, 8, b)));
        access(1'b0, 0, 32'h0, rv);
        chk(rv == 32'h5EED5EED, "R9 no page wrap", rv, 32'h5EED5EED);
        repeat (60) @(negedge clk);
      end
    end
    chk(proto_err == 0, "R3 R4 R11 lane/idle protocol", 32'(proto_err), 0);
    chk(min_gap >= 2, "R11 deselect gap", 32'(min_gap), 2);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule